// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether an incoming CAN frame is accepted, and which receive buffer takes it. On a frame-valid strobe it compares the received identifier and its format flag with the identifier and format stored for each of sixteen receive buffers. The comparison runs under programmable masks. Buffers 0 to 13 share one global mask. Buffers 14 and 15 each have a dedicated mask.

Each mask has 29 active bits. A 1 means the identifier bit must be equal, and a 0 means the bit is a don't-care. The upper 11 mask bits cover the standard identifier, which is carried in identifier bits 28:18. These bits take part for both formats. The lower 18 bits take part only for extended frames. Among enabled buffers that match, the lowest-numbered one wins. The result is registered and appears one cycle after the strobe. The host writes and reads the masks through a simple register port.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, every mask reads 0x1FFFFFFF: bits 28:0 are 1 and bits 31:29 are 0.
- R2: With `mask_we_i` high at a clock edge, `mask_sel_i` picks the mask to write: 0 for the global mask, 1 for the buffer 14 mask, 2 for the buffer 15 mask. Bits 31:29 of the write data are dropped, and `mask_rdata_o` returns the mask picked by `mask_rsel_i` with bits 31:29 at zero. Select 3 writes nothing and reads as 0.
- R3: A mask bit of 1 requires the frame and buffer identifier bits at that position to be equal. A mask bit of 0 lets them differ.
- R4: Buffers 0 to 13 are compared under the global mask only. Buffer 14 is compared only under its own mask, and buffer 15 only under its own mask.
- R5: For a standard frame (`frame_ext_i`=0), identifier bits 17:0 of the frame and of the buffer have no effect on the result, whatever the mask holds.
- R6: A buffer matches only if its format flag equals `frame_ext_i`, even when the mask is all zero.
- R7: A buffer whose enable bit is 0 never matches.
- R8: When several buffers match, `match_idx_o` reports the lowest-numbered one.
- R9: One cycle after a strobe, `result_vld_o` is 1 for exactly one cycle. In that cycle `match_o` shows whether any buffer matched and `match_idx_o` holds the winner, or 0 on a miss. At all other times `match_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | Received frame strobe |
| frame_id_i | input | 29 | Received identifier; the standard ID is in bits 28:18 |
| frame_ext_i | input | 1 | Received frame is in extended format |
| buf_id_i | input | 464 | Stored identifier per buffer; buffer n is in bits 29n+28:29n |
| buf_ext_i | input | 16 | Format flag per buffer |
| buf_en_i | input | 16 | Buffer enabled for reception |
| mask_we_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 2 | Write target: 0 global, 1 buffer 14, 2 buffer 15 |
| mask_wdata_i | input | 32 | Mask write data |
| mask_rsel_i | input | 2 | Read select, same encoding as the write target |
| mask_rdata_o | output | 32 | Selected mask; bits 31:29 are zero |
| result_vld_o | output | 1 | Result cycle, one cycle after the strobe |
| match_o | output | 1 | Frame accepted by some buffer |
| match_idx_o | output | 4 | Index of the accepting buffer |

## Verification
On every cycle the assertions check the following. The result strobe must follow the frame strobe by exactly one cycle, and an accept may appear only in a result cycle. The chosen buffer must have been enabled, must have agreed in format with the frame, and must be the lowest buffer in the hit set. The reserved read bits must stay zero. Only the directed scenarios can show that each mask is applied to the right buffers, that a don't-care bit really admits a differing identifier, and that the low identifier bits are ignored for standard frames, because these depend on concrete identifier and mask values.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int ID_W     = 29;
  localparam int STD_W    = 11;
  localparam int EXT_W    = ID_W - STD_W;
  localparam int REG_W    = 32;
  localparam int NUM_MASK = 3;
  localparam int SEL_W    = 2;

  typedef logic [ID_W-1:0] can_id_t;

  localparam logic [SEL_W-1:0] SEL_GLOBAL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_BUF_A  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_BUF_B  = 2'd2;
endpackage

// File: rtl/can_acc_mask_regs.sv
module can_acc_mask_regs
  import can_acc_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [REG_W-1:0]                wdata_i,
  input  logic [SEL_W-1:0]                rsel_i,
  output logic [REG_W-1:0]                rdata_o,
  output logic [NUM_MASK-1:0][ID_W-1:0]   mask_o
);
  logic [NUM_MASK-1:0][ID_W-1:0] mask_q;

  for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mask_q[m] <= '1;
      else if (we_i && (sel_i == SEL_W'(m)))
        mask_q[m] <= wdata_i[ID_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int m = 0; m < NUM_MASK; m++)
      if (rsel_i == SEL_W'(m)) rdata_o[ID_W-1:0] = mask_q[m];
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/can_acc_cmp.sv
module can_acc_cmp
  import can_acc_pkg::*;
(
  input  can_id_t   frame_id_i,
  input  logic      frame_ext_i,
  input  can_id_t   buf_id_i,
  input  logic      buf_ext_i,
  input  logic      buf_en_i,
  input  can_id_t   mask_i,
  output logic      hit_o
);
  can_id_t eff_mask;
  can_id_t diff;

  // low part only counts for extended frames
  assign eff_mask = {mask_i[ID_W-1:EXT_W], mask_i[EXT_W-1:0] & {EXT_W{frame_ext_i}}};
  assign diff     = (frame_id_i ^ buf_id_i) & eff_mask;
  assign hit_o    = buf_en_i && (buf_ext_i == frame_ext_i) && (diff == '0);
endmodule

// File: rtl/can_acc_prio.sv
module can_acc_prio #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_i[i]) idx_o = IDX_W'(i);
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acc_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_vld_i,
  input  logic [ID_W-1:0]         frame_id_i,
  input  logic                    frame_ext_i,
  input  logic [NUM_BUF*ID_W-1:0] buf_id_i,
  input  logic [NUM_BUF-1:0]      buf_ext_i,
  input  logic [NUM_BUF-1:0]      buf_en_i,
  input  logic                    mask_we_i,
  input  logic [SEL_W-1:0]        mask_sel_i,
  input  logic [REG_W-1:0]        mask_wdata_i,
  input  logic [SEL_W-1:0]        mask_rsel_i,
  output logic [REG_W-1:0]        mask_rdata_o,
  output logic                    result_vld_o,
  output logic                    match_o,
  output logic [IDX_W-1:0]        match_idx_o
);
  logic [NUM_MASK-1:0][ID_W-1:0] mask_w;
  logic [NUM_BUF-1:0]            hit_w;
  logic                          any_w;
  logic [IDX_W-1:0]              idx_w;

  can_acc_mask_regs u_masks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .sel_i   (mask_sel_i),
    .wdata_i (mask_wdata_i),
    .rsel_i  (mask_rsel_i),
    .rdata_o (mask_rdata_o),
    .mask_o  (mask_w)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    can_id_t sel_mask;
    if (b == NUM_BUF - 2) begin : g_ded_a
      assign sel_mask = mask_w[1];
    end else if (b == NUM_BUF - 1) begin : g_ded_b
      assign sel_mask = mask_w[2];
    end else begin : g_glob
      assign sel_mask = mask_w[0];
    end

    can_acc_cmp u_cmp (
      .frame_id_i  (frame_id_i),
      .frame_ext_i (frame_ext_i),
      .buf_id_i    (buf_id_i[b*ID_W +: ID_W]),
      .buf_ext_i   (buf_ext_i[b]),
      .buf_en_i    (buf_en_i[b]),
      .mask_i      (sel_mask),
      .hit_o       (hit_w[b])
    );
  end

  can_acc_prio #(.N(NUM_BUF)) u_prio (
    .hit_i (hit_w),
    .any_o (any_w),
    .idx_o (idx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_vld_o <= 1'b0;
      match_o      <= 1'b0;
      match_idx_o  <= '0;
    end else begin
      result_vld_o <= frame_vld_i;
      match_o      <= frame_vld_i && any_w;
      if (frame_vld_i) match_idx_o <= any_w ? idx_w : '0;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_BUF = 16,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_vld_i,
  input logic               frame_ext_i,
  input logic [NUM_BUF-1:0] buf_ext_i,
  input logic [NUM_BUF-1:0] buf_en_i,
  input logic [NUM_BUF-1:0] hit_w,
  input logic               result_vld_o,
  input logic               match_o,
  input logic [IDX_W-1:0]   match_idx_o,
  input logic [31:0]        mask_rdata_o
);
  logic [NUM_BUF-1:0] en_q, ext_q, hit_q;
  logic               fext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0; ext_q <= '0; hit_q <= '0; fext_q <= 1'b0;
    end else begin
      en_q <= buf_en_i; ext_q <= buf_ext_i; hit_q <= hit_w; fext_q <= frame_ext_i;
    end
  end

  a_r9_strobe_to_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> result_vld_o);
  a_r9_no_spurious_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> !result_vld_o);
  a_r9_match_in_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> result_vld_o);
  a_r7_enabled_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> en_q[match_idx_o]);
  a_r6_format_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (ext_q[match_idx_o] == fext_q));
  a_r8_lowest_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (hit_q[match_idx_o] &&
                 ((hit_q & ((NUM_BUF'(1) << match_idx_o) - NUM_BUF'(1))) == '0)));
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_rdata_o[31:29] == 3'b000);
endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_vld_i  (frame_vld_i),
  .frame_ext_i  (frame_ext_i),
  .buf_ext_i    (buf_ext_i),
  .buf_en_i     (buf_en_i),
  .hit_w        (hit_w),
  .result_vld_o (result_vld_o),
  .match_o      (match_o),
  .match_idx_o  (match_idx_o),
  .mask_rdata_o (mask_rdata_o)
);

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;
  localparam int NB = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic frame_vld_i = 1'b0, frame_ext_i = 1'b0;
  logic [28:0] frame_id_i = '0;
  logic [28:0] bid [NB];
  logic [NB*29-1:0] buf_id_i;
  logic [NB-1:0] buf_ext_i = '0, buf_en_i = '0;
  logic mask_we_i = 1'b0;
  logic [1:0] mask_sel_i = '0, mask_rsel_i = '0;
  logic [31:0] mask_wdata_i = '0, mask_rdata_o;
  logic result_vld_o, match_o;
  logic [3:0] match_idx_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  always_comb for (int i = 0; i < NB; i++) buf_id_i[i*29 +: 29] = bid[i];

  can_accept_filter u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i); mask_we_i = 1'b1; mask_sel_i = sel; mask_wdata_i = d;
    @(negedge clk_i); mask_we_i = 1'b0;
  endtask

  task automatic rd_mask(input string req, input logic [1:0] sel, input logic [31:0] exp);
    mask_rsel_i = sel; #1;
    chk(req, mask_rdata_o, exp);
  endtask

  task automatic set_buf(input int i, input logic [28:0] id, input logic ext, input logic en);
    bid[i] = id; buf_ext_i[i] = ext; buf_en_i[i] = en;
  endtask

  task automatic clr_bufs();
    for (int i = 0; i < NB; i++) set_buf(i, '0, 1'b0, 1'b0);
  endtask

  task automatic send(input string req, input logic [28:0] id, input logic ext,
                      input logic em, input logic [3:0] ei);
    @(negedge clk_i); frame_id_i = id; frame_ext_i = ext; frame_vld_i = 1'b1;
    @(negedge clk_i); frame_vld_i = 1'b0;
    chk({req, " R9 vld"}, {31'd0, result_vld_o}, 32'd1);
    chk({req, " match"}, {31'd0, match_o}, {31'd0, em});
    chk({req, " idx"}, {28'd0, match_idx_o}, {28'd0, em ? ei : 4'd0});
    @(negedge clk_i);
    chk("R9 pulse end", {30'd0, result_vld_o, match_o}, 32'd0);
  endtask

  task automatic t_reset();
    rd_mask("R1 global", 2'd0, 32'h1FFF_FFFF);
    rd_mask("R1 mask14", 2'd1, 32'h1FFF_FFFF);
    rd_mask("R1 mask15", 2'd2, 32'h1FFF_FFFF);
    chk("R9 reset", {30'd0, result_vld_o, match_o}, 32'd0);
  endtask

  task automatic t_mask_rw();
    wr_mask(2'd0, 32'hFFFF_FFFF);
    rd_mask("R2 reserved dropped", 2'd0, 32'h1FFF_FFFF);
    wr_mask(2'd2, 32'hF234_5678);
    rd_mask("R2 mask15 write", 2'd2, 32'h1234_5678);
    rd_mask("R2 mask14 untouched", 2'd1, 32'h1FFF_FFFF);
    wr_mask(2'd3, 32'h0);
    rd_mask("R2 sel3 no write", 2'd0, 32'h1FFF_FFFF);
    rd_mask("R2 sel3 reads zero", 2'd3, 32'h0);
    wr_mask(2'd2, 32'h1FFF_FFFF);
  endtask

  task automatic t_exact();
    clr_bufs();
    set_buf(5, 29'h0ABC_1234, 1'b1, 1'b1);
    send("R3 exact", 29'h0ABC_1234, 1'b1, 1'b1, 4'd5);
    send("R3 bit0 differs", 29'h0ABC_1235, 1'b1, 1'b0, 4'd0);
  endtask

  task automatic t_dontcare();
    wr_mask(2'd0, 32'h1FFF_FFFE);
    send("R3 dont care bit0", 29'h0ABC_1235, 1'b1, 1'b1, 4'd5);
    send("R3 bit1 still checked", 29'h0ABC_1236, 1'b1, 1'b0, 4'd0);
    wr_mask(2'd0, 32'h1FFF_FFFF);
  endtask

  task automatic t_standard();
    clr_bufs();
    set_buf(7, {11'h5A3, 18'h12345}, 1'b0, 1'b1);
    send("R5 low bits ignored", {11'h5A3, 18'h3FFFF}, 1'b0, 1'b1, 4'd7);
    send("R5 std id differs", {11'h5A2, 18'h12345}, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_format();
    wr_mask(2'd0, 32'h0);
    send("R6 std any id", 29'h1555_5555, 1'b0, 1'b1, 4'd7);
    send("R6 format mismatch", {11'h5A3, 18'h12345}, 1'b1, 1'b0, 4'd0);
  endtask

  task automatic t_disabled();
    clr_bufs();
    send("R7 all disabled", 29'h0000_0042, 1'b1, 1'b0, 4'd0);
    set_buf(9, 29'h0000_0777, 1'b1, 1'b1);
    send("R7 enabled buf9", 29'h0000_0042, 1'b1, 1'b1, 4'd9);
    wr_mask(2'd0, 32'h1FFF_FFFF);
  endtask

  task automatic t_dedicated();
    clr_bufs();
    set_buf(3, 29'h0333_0003, 1'b1, 1'b1);
    set_buf(14, 29'h0EEE_000E, 1'b1, 1'b1);
    set_buf(15, 29'h0FFF_000F, 1'b1, 1'b1);
    wr_mask(2'd1, 32'h0);
    send("R4 mask14 open", 29'h0123_4567, 1'b1, 1'b1, 4'd14);
    wr_mask(2'd1, 32'h1FFF_FFFF);
    wr_mask(2'd2, 32'h0);
    send("R4 mask15 open", 29'h0123_4567, 1'b1, 1'b1, 4'd15);
    wr_mask(2'd2, 32'h1FFF_FFFF);
    wr_mask(2'd0, 32'h0);
    send("R4 global open hits 3", 29'h0123_4567, 1'b1, 1'b1, 4'd3);
    buf_en_i[3] = 1'b0;
    send("R4 global not on 14/15", 29'h0123_4567, 1'b1, 1'b0, 4'd0);
    wr_mask(2'd0, 32'h1FFF_FFFF);
  endtask

  task automatic t_priority();
    clr_bufs();
    set_buf(2, 29'h1234_5678, 1'b1, 1'b1);
    set_buf(9, 29'h1234_5678, 1'b1, 1'b1);
    send("R8 2 over 9", 29'h1234_5678, 1'b1, 1'b1, 4'd2);
    clr_bufs();
    set_buf(14, 29'h1234_5678, 1'b1, 1'b1);
    set_buf(15, 29'h1234_5678, 1'b1, 1'b1);
    send("R8 14 over 15", 29'h1234_5678, 1'b1, 1'b1, 4'd14);
    clr_bufs();
    set_buf(0, 29'h1234_5678, 1'b1, 1'b1);
    set_buf(15, 29'h1234_5678, 1'b1, 1'b1);
    send("R8 0 over 15", 29'h1234_5678, 1'b1, 1'b1, 4'd0);
    send("R9 miss idx zero", 29'h1234_5679, 1'b1, 1'b0, 4'd0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) bid[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask_rw();
    t_exact();
    t_dontcare();
    t_standard();
    t_format();
    t_disabled();
    t_dedicated();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule